// File: doc/BRIEF.md
# Interrupt Rate Moderator

This block sits between a network controller's interrupt cause and mask vectors and its single interrupt line. It merges bursts of events into fewer interrupts by holding back only the rising edge of the line for a programmable time. Falling edges, and edges that arrive while no hold-off window is open, pass through after one register stage.

When a rising edge is seen with the hold-off window closed and moderation switched on, the block picks a window length. It takes the smallest non-zero value among three candidates, each gated by its own condition:
- a throttle interval, which always takes part;
- a receive absolute delay, multiplied by four;
- a transmit absolute delay, multiplied by four.

Time advances on a free-running tick input worth 256 ns. The transmit candidate depends on a sticky flag that descriptor-processing logic sets through a strobe. The flag is cleared after every window evaluation.

Top module: `irq_moderator`

## Requirements
- R1: With `mod_en_i` low, `irq_o` equals "(cause_i & mask_i) is non-zero" sampled at the previous clock edge.
- R2: When `irq_o` is low, the pending set becomes non-zero and no window is open, `irq_o` rises at the next edge. A window of the computed length opens at the same time, if that length is non-zero.
- R3: With `mod_en_i` high and a window open (not expiring this cycle), a new non-zero pending set keeps `irq_o` low. The descriptor flag is also left unchanged.
- R4: The window length in ticks is the minimum of the non-zero enabled candidates. The throttle value is always a candidate. If every candidate is zero, no window opens.
- R5: The transmit candidate (transmit delay × 4) takes part only when the descriptor flag is set and cause bit 0 (descriptor written) or cause bit 1 (queue empty) is pending.
- R6: The receive candidate (receive delay × 4) takes part only when the receive-delay-enable register is non-zero and cause bit 7 (receive timer) is pending.
- R7: A cycle with `desc_done_i` and `desc_dly_i` both high sets the descriptor flag. Every window evaluation clears it, whether or not a window opens; a set in the same cycle wins.
- R8: A window of N ticks closes on the N-th `tick_i` after it opened. If causes are still pending in that cycle, the edge is evaluated again in the same cycle: `irq_o` rises at the next edge and a new window may open.
- R9: Register writes keep only `reg_wdata_i[15:0]`. `reg_sel_i` selects 0 = throttle, 1 = receive delay, 2 = transmit delay, 3 = receive delay enable.
- R10: A pending set of zero drives `irq_o` low at the next edge, whether or not a window is open.
- R11: Reset clears `irq_o`, closes the window, clears the descriptor flag and zeroes all four registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mod_en_i | input | 1 | Moderation enable |
| reg_we_i | input | 1 | Delay register write strobe |
| reg_sel_i | input | 2 | Delay register select |
| reg_wdata_i | input | 32 | Write data; only the low 16 bits are kept |
| cause_i | input | CW | Interrupt cause vector |
| mask_i | input | CW | Interrupt mask vector |
| desc_done_i | input | 1 | Transmit descriptor processed strobe |
| desc_dly_i | input | 1 | Delay-enable bit of that descriptor |
| tick_i | input | 1 | 256 ns time-base enable |
| irq_o | output | 1 | Interrupt line |

## Verification
The cause vector is pulsed, cleared and re-raised every cycle. As a result, the cycle in which a held edge finally rises shows exactly which candidate won the minimum. These patterns are repeated under each gating combination:
- the throttle alone;
- the transmit delay with and without a latched descriptor flag, and with a non-transmit cause;
- the receive delay with its enable zero and non-zero;
- all-zero delays.

A slow tick separates a count kept in ticks from one kept in clocks. A write with bits above 15 set exposes truncation. A reset in the middle of a window, and a run with moderation off, check the idle and pass-through paths.

// File: rtl/imod_pkg.sv
package imod_pkg;
  localparam int unsigned DLY_W = 16;
  localparam int unsigned CNT_W = DLY_W + 2;

  typedef enum logic [1:0] {
    SEL_THR  = 2'd0,
    SEL_RXA  = 2'd1,
    SEL_TXA  = 2'd2,
    SEL_RXEN = 2'd3
  } dly_sel_e;

  typedef struct packed {
    logic [DLY_W-1:0] thr;
    logic [DLY_W-1:0] rxa;
    logic [DLY_W-1:0] txa;
    logic [DLY_W-1:0] rxen;
  } dly_regs_t;
endpackage

// File: rtl/imod_regs.sv
module imod_regs
  import imod_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  sel_i,
  input  logic [31:0] wdata_i,
  output dly_regs_t   regs_o
);
  dly_regs_t regs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_q <= '0;
    end else if (we_i) begin
      unique case (dly_sel_e'(sel_i))
        SEL_THR:  regs_q.thr  <= wdata_i[DLY_W-1:0];
        SEL_RXA:  regs_q.rxa  <= wdata_i[DLY_W-1:0];
        SEL_TXA:  regs_q.txa  <= wdata_i[DLY_W-1:0];
        SEL_RXEN: regs_q.rxen <= wdata_i[DLY_W-1:0];
        default:  regs_q      <= regs_q;
      endcase
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/imod_min_pick.sv
module imod_min_pick #(
  parameter int unsigned N = 3,
  parameter int unsigned W = 18
) (
  input  logic [N-1:0][W-1:0] cand_i,
  input  logic [N-1:0]        use_i,
  output logic [W-1:0]        min_o
);
  // zero means "not set" at every stage of the chain
  logic [N:0][W-1:0] chain;
  assign chain[0] = '0;

  for (genvar g = 0; g < N; g++) begin : g_stage
    logic take;
    assign take = use_i[g] && (cand_i[g] != '0) &&
                  ((chain[g] == '0) || (cand_i[g] < chain[g]));
    assign chain[g+1] = take ? cand_i[g] : chain[g];
  end

  assign min_o = chain[N];
endmodule

// File: rtl/imod_timer.sv
module imod_timer #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         start_i,
  input  logic [W-1:0] load_i,
  output logic         run_o,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic         run_q;
  logic [W-1:0] cnt_q;

  assign expire_o = run_q && tick_i && (cnt_q == W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cnt_q <= load_i;
    end else if (expire_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/irq_moderator.sv
module irq_moderator
  import imod_pkg::*;
#(
  parameter int unsigned CW       = 16,
  parameter int unsigned TXDW_BIT = 0,
  parameter int unsigned TXQE_BIT = 1,
  parameter int unsigned RXT_BIT  = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mod_en_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic [CW-1:0] cause_i,
  input  logic [CW-1:0] mask_i,
  input  logic          desc_done_i,
  input  logic          desc_dly_i,
  input  logic          tick_i,
  output logic          irq_o
);
  localparam int unsigned NSRC = 3;

  dly_regs_t regs;
  logic [CW-1:0] pend;
  logic          any_pend;
  logic          level_q, ide_q;
  logic          run_q, expire, run_eff;
  logic [CNT_W-1:0] cnt_q, win_len;
  logic          rise, held, eval, start;
  logic [NSRC-1:0][CNT_W-1:0] cand;
  logic [NSRC-1:0]            cand_use;

  imod_regs i_regs (
    .clk_i, .rst_ni,
    .we_i   (reg_we_i),
    .sel_i  (reg_sel_i),
    .wdata_i(reg_wdata_i),
    .regs_o (regs)
  );

  assign pend     = cause_i & mask_i;
  assign any_pend = |pend;

  // candidates: transmit, receive, throttle
  assign cand[0]     = {regs.txa, 2'b00};
  assign cand_use[0] = ide_q && (pend[TXDW_BIT] || pend[TXQE_BIT]);
  assign cand[1]     = {regs.rxa, 2'b00};
  assign cand_use[1] = (regs.rxen != '0) && pend[RXT_BIT];
  assign cand[2]     = CNT_W'(regs.thr);
  assign cand_use[2] = 1'b1;

  imod_min_pick #(.N(NSRC), .W(CNT_W)) i_pick (
    .cand_i(cand),
    .use_i (cand_use),
    .min_o (win_len)
  );

  imod_timer #(.W(CNT_W)) i_timer (
    .clk_i, .rst_ni,
    .tick_i,
    .start_i (start),
    .load_i  (win_len),
    .run_o   (run_q),
    .cnt_o   (cnt_q),
    .expire_o(expire)
  );

  // expiry re-runs the edge evaluation in the same cycle
  assign run_eff = run_q && !expire;
  assign rise    = !level_q && any_pend;
  assign held    = rise && run_eff && mod_en_i;
  assign eval    = rise && !run_eff && mod_en_i;
  assign start   = eval && (win_len != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b0;
      ide_q   <= 1'b0;
    end else begin
      level_q <= held ? 1'b0 : any_pend;
      ide_q   <= (eval ? 1'b0 : ide_q) | (desc_done_i & desc_dly_i);
    end
  end

  assign irq_o = level_q;
endmodule

// File: rtl/irq_moderator_chk.sv
module irq_moderator_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mod_en_i,
  input logic [CW-1:0] cause_i,
  input logic [CW-1:0] mask_i,
  input logic          tick_i,
  input logic          irq_o,
  input logic          run_q,
  input logic [17:0]   cnt_q
);
  // R1
  follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_i |=> irq_o == $past((cause_i & mask_i) != '0));

  // R10
  fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i & mask_i) == '0 |=> !irq_o);

  // R3
  hold_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_en_i && run_q && (cnt_q > 18'd1) && !irq_o |=> !irq_o);

  // R2
  rise_now_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !run_q && ((cause_i & mask_i) != '0) |=> irq_o);

  // R8
  tick_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q && !tick_i |=> run_q && $stable(cnt_q));

  // R4
  no_zero_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q != '0);
endmodule

bind irq_moderator irq_moderator_chk #(.CW(CW)) i_chk (
  .clk_i, .rst_ni, .mod_en_i, .cause_i, .mask_i, .tick_i, .irq_o,
  .run_q, .cnt_q
);

// File: tb/test_irq_moderator.sv
module test_irq_moderator;
  localparam time CLK_P = 10ns;
  localparam int CW = 16;

  logic clk = 0, rst_ni = 0;
  logic mod_en = 0, reg_we = 0, desc_done = 0, desc_dly = 0, tick = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [CW-1:0] cause = 0, mask = 0;
  logic irq;

  always #(CLK_P/2) clk = ~clk;

  irq_moderator i_irq_moderator (
    .clk_i(clk), .rst_ni, .mod_en_i(mod_en), .reg_we_i(reg_we),
    .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .cause_i(cause),
    .mask_i(mask), .desc_done_i(desc_done), .desc_dly_i(desc_dly),
    .tick_i(tick), .irq_o(irq)
  );

  int n_vec = 0, n_bad = 0;
  string cur_req = "R11";
  int tick_div = 1, phase = 0;

  // reference model
  int m_regs[4];
  bit m_level, m_run, m_ide;
  int m_cnt;

  task automatic model_reset();
    foreach (m_regs[i]) m_regs[i] = 0;
    m_level = 0; m_run = 0; m_ide = 0; m_cnt = 0;
  endtask

  task automatic model_step();
    bit [CW-1:0] p = cause & mask;
    bit exp_now = m_run && tick && m_cnt == 1;
    bit still = m_run && !exp_now;
    bit edge_up = !m_level && p != 0;
    bit ev = 0;
    int d = 0;
    int c;
    if (edge_up && still && mod_en) begin
      // held low
    end else begin
      if (edge_up && mod_en) begin
        ev = 1;
        if (m_ide && (p[0] || p[1]) && m_regs[2] != 0) d = m_regs[2] * 4;
        if (m_regs[3] != 0 && p[7] && m_regs[1] != 0) begin
          c = m_regs[1] * 4;
          if (d == 0 || c < d) d = c;
        end
        if (m_regs[0] != 0 && (d == 0 || m_regs[0] < d)) d = m_regs[0];
      end
      m_level = (p != 0);
    end
    if (ev && d != 0) begin m_run = 1; m_cnt = d; end
    else if (exp_now) begin m_run = 0; m_cnt = 0; end
    else if (m_run && tick) m_cnt--;
    if (ev) m_ide = 0;
    if (desc_done && desc_dly) m_ide = 1;
    if (reg_we) m_regs[reg_sel] = reg_wdata & 32'hFFFF;
  endtask

  task automatic compare();
    n_vec++;
    if (irq !== m_level) begin
      n_bad++;
      $display("FAIL %s t=%0t irq_o actual=%0b expected=%0b", cur_req, $time, irq, m_level);
    end
  endtask

  // one clock: inputs already set; model at edge; compare at negedge
  task automatic cyc();
    @(posedge clk);
    if (rst_ni) model_step(); else model_reset();
    @(negedge clk);
    compare();
    reg_we = 0; desc_done = 0; desc_dly = 0;
    phase++;
    tick = (phase % tick_div) == 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic wr(int sel, logic [31:0] v);
    reg_we = 1; reg_sel = 2'(sel); reg_wdata = v;
    cyc();
  endtask

  // raise cause, drop it, then keep re-raising so the held edge shows its window
  task automatic burst(logic [CW-1:0] c, int n);
    cause = c; cyc();
    cause = 0; cyc();
    cause = c; run(n);
    cause = 0; run(2);
  endtask

  task automatic do_reset();
    rst_ni = 0; cause = 0; run(2);
    rst_ni = 1; run(1);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    mask = '1;
    tick = 1;
    cur_req = "R11"; do_reset();
    cause = 16'h0001; cyc();  // R11: registers zero, so no window

    cur_req = "R1"; mod_en = 0;
    cause = 16'h0004; cyc(); cause = 0; cyc();
    mask = 16'h00F0; cause = 16'h000F; run(2);
    cause = 16'h0010; run(2); mask = '1; cause = 0; cyc();

    mod_en = 1;
    cur_req = "R2"; wr(0, 5);
    burst(16'h0004, 10);
    cur_req = "R3"; burst(16'h0100, 4);
    cur_req = "R10"; cause = 16'h0004; cyc(); cause = 0; run(3);
    cur_req = "R8"; run(6); burst(16'h0004, 14);

    cur_req = "R5"; wr(0, 10); wr(2, 1); run(12);
    desc_done = 1; desc_dly = 1; cyc();
    burst(16'h0001, 14);                 // R5 tx window 4
    run(12); burst(16'h0001, 14);         // R7 flag cleared -> 10
    run(12); desc_done = 1; desc_dly = 1; cyc();
    burst(16'h0020, 14);                  // R5 non-tx cause
    run(12); desc_done = 1; cyc(); burst(16'h0002, 14);  // R7 no dly bit

    cur_req = "R6"; wr(1, 2); run(12);
    burst(16'h0080, 14);                  // R6 rxen zero -> 10
    wr(3, 1); run(12); burst(16'h0080, 14);  // R6 -> 8
    run(12); burst(16'h0040, 14);

    cur_req = "R4"; wr(0, 0); wr(1, 0); wr(2, 0); run(12);
    burst(16'h0080, 4);
    wr(2, 3); wr(1, 2); wr(0, 20); run(25);
    desc_done = 1; desc_dly = 1; cyc();
    burst(16'h0081, 16);                  // R4 min(12,8,20)=8

    cur_req = "R9"; wr(0, 32'h0001_0003); wr(1, 0); wr(2, 0); run(30);
    burst(16'h0004, 8);

    cur_req = "R8"; tick_div = 3; wr(0, 4); run(20);
    burst(16'h0004, 20);

    cur_req = "R11"; tick_div = 1; wr(0, 50);
    cause = 16'h0004; cyc(); cause = 0; run(2);
    do_reset();
    cause = 16'h0004; run(3);             // R11 window and throttle cleared

    cur_req = "R7"; wr(2, 2); wr(0, 30); cause = 0; run(2);
    desc_done = 1; desc_dly = 1; cause = 16'h0001; cyc();
    burst(16'h0001, 40);                  // R7 same-cycle set survives eval -> 8

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule